// File: doc/BRIEF.md
# Two-Thread Integer Register Renamer

This block translates the architectural register names of integer macro-ops into physical register numbers drawn from one shared pool. The name space per thread holds the general-purpose registers together with the scratch registers that microcoded sequences use, `ARCH` names in all. Each of two hardware threads owns a speculative map, consulted and updated at rename time, and a committed map, updated at retirement. A group of up to `GROUP` slots arrives each cycle with one thread number. Every valid slot reads two source mappings. Every valid slot that writes a result also receives a newly allocated physical register. The renamed numbers come back combinationally in the same cycle.

The pool holds `PHYS` registers. After reset, thread t owns registers t*ARCH up to t*ARCH+ARCH-1 as its committed state, and every other register is free. Retirement names a thread, an architectural register and the physical register that now commits for it. The register that held that name before is returned to the pool. A flush request for one thread rebuilds that thread's speculative map from its committed map and reclaims every register the thread allocated that has not yet committed.

Control is a two-state machine. `ST_RUN` is the normal rename state. `ST_RUN` goes to `ST_FLUSH` on a flush request, and `ST_FLUSH` remains in `ST_FLUSH` if another request arrives. `ST_FLUSH` is the single cycle in which the latched thread is restored and reclaimed. `ST_FLUSH` returns to `ST_RUN` when no new request is present. No group is accepted in a cycle where a flush is requested, nor in any `ST_FLUSH` cycle.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register a of thread t maps to physical register t*ARCH+a in both maps, and all registers from NTHR*ARCH upward are free.
- R2: A source of a slot returns the physical register that the group's thread currently maps in its speculative map.
- R3: A source that names the destination of an earlier writing slot in the same group returns that slot's newly allocated register, and the latest such slot wins.
- R4: Each valid slot with its write flag set gets the lowest-numbered free register not taken by a lower slot. Slots that are invalid, or that do not write, consume nothing, and their destination output is 0.
- R5: `grp_ready_o` is high in `ST_RUN` when no flush is requested and the free count is at least the number of writing slots. When a group is refused, the maps and the pool stay unchanged.
- R6: A retirement frees the register previously committed for that name, and the register is allocatable from the next cycle.
- R7: `grp_ready_o` is low in the cycle of a flush request and in the `ST_FLUSH` cycle that follows. After that, the flushed thread's speculative map equals its committed map, including a retirement made in the `ST_FLUSH` cycle.
- R8: A flush returns to the pool every register that the flushed thread allocated and that has not committed.
- R9: The two threads' maps are independent: renames, retirements and flushes of one thread leave the other's mappings unchanged.
- R10: A group in which all GROUP slots write is renamed in a single cycle when enough registers are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid_i | input | 1 | A rename group is offered |
| grp_thread_i | input | TW | Thread of the group |
| slot_valid_i | input | GROUP | Slot holds a macro-op |
| slot_wr_i | input | GROUP | Slot produces a result register |
| slot_dst_i | input | GROUP*AW | Destination architectural name per slot |
| slot_srca_i | input | GROUP*AW | First source name per slot |
| slot_srcb_i | input | GROUP*AW | Second source name per slot |
| grp_ready_o | output | 1 | Group accepted this cycle when valid |
| slot_srca_p_o | output | GROUP*PW | Physical register for the first source |
| slot_srcb_p_o | output | GROUP*PW | Physical register for the second source |
| slot_dst_p_o | output | GROUP*PW | Newly allocated destination register |
| ret_valid_i | input | 1 | A destination mapping commits |
| ret_thread_i | input | TW | Thread of the commit |
| ret_arch_i | input | AW | Committing architectural name |
| ret_phys_i | input | PW | Physical register that becomes committed |
| flush_i | input | 1 | Flush request |
| flush_thread_i | input | TW | Thread to flush |

## Verification
A lost or duplicated free bit shows up as a wrong destination number at the next group that allocates past that index. It also shifts the cycle in which `grp_ready_o` falls when the pool drains. A stale speculative or committed map entry is visible at the first later source read of that name. After a flush, this is the first group of that thread. A reclaim bit on the wrong owner changes the allocation sequence within a few groups. The bench exposes each of these by comparing every source and destination number and the ready level on every cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_pick.sv
// Chooses, slot by slot, the lowest free register not already taken by a lower slot.
module rn_pick #(
    parameter int PHYS  = 180,
    parameter int GROUP = 6,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic [PHYS-1:0]             free_i,
    input  logic [GROUP-1:0]            need_i,
    output logic [GROUP-1:0][PW-1:0]    idx_o
);
    logic [PHYS-1:0] avail;
    logic            found;

    always_comb begin
        avail = free_i;
        for (int g = 0; g < GROUP; g++) begin
            idx_o[g] = '0;
            found    = 1'b0;
            if (need_i[g]) begin
                for (int p = 0; p < PHYS; p++) begin
                    if (!found && avail[p]) begin
                        idx_o[g] = PW'(p);
                        found    = 1'b1;
                    end
                end
                if (found) avail[idx_o[g]] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rn_map_bank.sv
// Speculative and committed map of one thread.
module rn_map_bank #(
    parameter int ARCH  = 38,
    parameter int PHYS  = 180,
    parameter int GROUP = 6,
    parameter int BASE  = 0,
    localparam int AW   = $clog2(ARCH),
    localparam int PW   = $clog2(PHYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [GROUP-1:0]            wr_en,
    input  logic [GROUP-1:0][AW-1:0]    wr_arch,
    input  logic [GROUP-1:0][PW-1:0]    wr_phys,
    input  logic                        cm_en,
    input  logic [AW-1:0]               cm_arch,
    input  logic [PW-1:0]               cm_phys,
    input  logic                        restore,
    output logic [ARCH-1:0][PW-1:0]     spec_o,
    output logic [ARCH-1:0][PW-1:0]     commit_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARCH; a++) begin
                spec_o[a]   <= PW'(BASE + a);
                commit_o[a] <= PW'(BASE + a);
            end
        end else begin
            if (cm_en) commit_o[cm_arch] <= cm_phys;
            if (restore) begin
                for (int a = 0; a < ARCH; a++)
                    spec_o[a] <= (cm_en && cm_arch == AW'(a)) ? cm_phys : commit_o[a];
            end else begin
                // later slots are written last and win
                for (int g = 0; g < GROUP; g++)
                    if (wr_en[g]) spec_o[wr_arch[g]] <= wr_phys[g];
            end
        end
    end
endmodule

// File: rtl/rn_pool.sv
// Per-register occupancy, owning thread and committed flag.
module rn_pool #(
    parameter int PHYS  = 180,
    parameter int ARCH  = 38,
    parameter int GROUP = 6,
    parameter int NTHR  = 2,
    localparam int PW   = $clog2(PHYS),
    localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [GROUP-1:0]            al_en,
    input  logic [GROUP-1:0][PW-1:0]    al_idx,
    input  logic [TW-1:0]               al_thr,
    input  logic                        rt_en,
    input  logic [PW-1:0]               rt_old,
    input  logic [PW-1:0]               rt_new,
    input  logic                        rc_en,
    input  logic [TW-1:0]               rc_thr,
    output logic [PHYS-1:0]             free_o
);
    logic [PHYS-1:0] used;
    logic [PHYS-1:0] cmt;
    logic [TW-1:0]   owner [PHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHYS; p++) begin
                used[p]  <= (p < NTHR * ARCH);
                cmt[p]   <= (p < NTHR * ARCH);
                owner[p] <= TW'(p / ARCH);
            end
        end else begin
            if (rc_en) begin
                for (int p = 0; p < PHYS; p++)
                    if (used[p] && !cmt[p] && owner[p] == rc_thr) used[p] <= 1'b0;
            end
            for (int g = 0; g < GROUP; g++) begin
                if (al_en[g]) begin
                    used[al_idx[g]]  <= 1'b1;
                    cmt[al_idx[g]]   <= 1'b0;
                    owner[al_idx[g]] <= al_thr;
                end
            end
            // retirement placed last so it overrides a same-cycle reclaim
            if (rt_en) begin
                used[rt_old] <= 1'b0;
                cmt[rt_old]  <= 1'b0;
                used[rt_new] <= 1'b1;
                cmt[rt_new]  <= 1'b1;
            end
        end
    end

    assign free_o = ~used;
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
    parameter int GROUP = 6,
    parameter int ARCH  = 38,
    parameter int PHYS  = 180,
    parameter int NTHR  = 2,
    localparam int AW   = $clog2(ARCH),
    localparam int PW   = $clog2(PHYS),
    localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        grp_valid_i,
    input  logic [TW-1:0]               grp_thread_i,
    input  logic [GROUP-1:0]            slot_valid_i,
    input  logic [GROUP-1:0]            slot_wr_i,
    input  logic [GROUP-1:0][AW-1:0]    slot_dst_i,
    input  logic [GROUP-1:0][AW-1:0]    slot_srca_i,
    input  logic [GROUP-1:0][AW-1:0]    slot_srcb_i,
    output logic                        grp_ready_o,
    output logic [GROUP-1:0][PW-1:0]    slot_srca_p_o,
    output logic [GROUP-1:0][PW-1:0]    slot_srcb_p_o,
    output logic [GROUP-1:0][PW-1:0]    slot_dst_p_o,
    input  logic                        ret_valid_i,
    input  logic [TW-1:0]               ret_thread_i,
    input  logic [AW-1:0]               ret_arch_i,
    input  logic [PW-1:0]               ret_phys_i,
    input  logic                        flush_i,
    input  logic [TW-1:0]               flush_thread_i
);
    import rn_pkg::*;

    rn_state_e                           state, state_nxt;
    logic [TW-1:0]                       fl_thr;
    logic                                in_run;
    logic                                fire;
    logic [GROUP-1:0]                    need;
    logic [PHYS-1:0]                     free_vec;
    logic [GROUP-1:0][PW-1:0]            alloc;
    logic [NTHR-1:0][ARCH-1:0][PW-1:0]   spec_all;
    logic [NTHR-1:0][ARCH-1:0][PW-1:0]   commit_all;
    logic [PW-1:0]                       ret_old;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            fl_thr <= '0;
        end else begin
            state <= state_nxt;
            if (flush_i) fl_thr <= flush_thread_i;
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:   state_nxt = flush_i ? ST_FLUSH : ST_RUN;
            ST_FLUSH: state_nxt = flush_i ? ST_FLUSH : ST_RUN;
            default:  state_nxt = ST_RUN;
        endcase
    end

    // outputs and acceptance
    always_comb begin
        for (int g = 0; g < GROUP; g++)
            need[g] = grp_valid_i && slot_valid_i[g] && slot_wr_i[g];
        in_run      = (state == ST_RUN);
        grp_ready_o = in_run && !flush_i && ($countones(free_vec) >= $countones(need));
        fire        = grp_valid_i && grp_ready_o;
        for (int g = 0; g < GROUP; g++) begin
            slot_srca_p_o[g] = spec_all[grp_thread_i][slot_srca_i[g]];
            slot_srcb_p_o[g] = spec_all[grp_thread_i][slot_srcb_i[g]];
            for (int j = 0; j < g; j++) begin
                if (need[j] && slot_dst_i[j] == slot_srca_i[g]) slot_srca_p_o[g] = alloc[j];
                if (need[j] && slot_dst_i[j] == slot_srcb_i[g]) slot_srcb_p_o[g] = alloc[j];
            end
            slot_dst_p_o[g] = need[g] ? alloc[g] : '0;
        end
        ret_old = commit_all[ret_thread_i][ret_arch_i];
    end

    rn_pick #(.PHYS(PHYS), .GROUP(GROUP)) u_pick (
        .free_i (free_vec),
        .need_i (need),
        .idx_o  (alloc)
    );

    rn_pool #(.PHYS(PHYS), .ARCH(ARCH), .GROUP(GROUP), .NTHR(NTHR)) u_pool (
        .clk    (clk),
        .rst_n  (rst_n),
        .al_en  (fire ? need : '0),
        .al_idx (alloc),
        .al_thr (grp_thread_i),
        .rt_en  (ret_valid_i),
        .rt_old (ret_old),
        .rt_new (ret_phys_i),
        .rc_en  (state == ST_FLUSH),
        .rc_thr (fl_thr),
        .free_o (free_vec)
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        rn_map_bank #(.ARCH(ARCH), .PHYS(PHYS), .GROUP(GROUP), .BASE(t * ARCH)) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    ((fire && grp_thread_i == TW'(t)) ? need : '0),
            .wr_arch  (slot_dst_i),
            .wr_phys  (alloc),
            .cm_en    (ret_valid_i && ret_thread_i == TW'(t)),
            .cm_arch  (ret_arch_i),
            .cm_phys  (ret_phys_i),
            .restore  (state == ST_FLUSH && fl_thr == TW'(t)),
            .spec_o   (spec_all[t]),
            .commit_o (commit_all[t])
        );
    end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int GROUP = 6,
    parameter int PHYS  = 180,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        grp_valid_i,
    input  logic                        grp_ready_o,
    input  logic                        flush_i,
    input  logic                        ret_valid_i,
    input  logic                        in_run,
    input  logic [GROUP-1:0]            need,
    input  logic [PHYS-1:0]             free_vec,
    input  logic [GROUP-1:0][PW-1:0]    slot_dst_p_o
);
    logic fire;
    logic dup;
    logic all_free;
    int   fcnt;
    int   ncnt;

    always_comb begin
        fire     = grp_valid_i && grp_ready_o;
        fcnt     = $countones(free_vec);
        ncnt     = $countones(need);
        dup      = 1'b0;
        all_free = 1'b1;
        for (int g = 0; g < GROUP; g++) begin
            if (need[g] && !free_vec[slot_dst_p_o[g]]) all_free = 1'b0;
            for (int j = 0; j < g; j++)
                if (need[g] && need[j] && slot_dst_p_o[g] == slot_dst_p_o[j]) dup = 1'b1;
        end
    end

    p_flush_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !grp_ready_o);
    p_flush_cycle_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !grp_ready_o);
    p_alloc_was_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> all_free);
    p_alloc_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !dup);
    p_pool_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ret_valid_i) |=> fcnt == $past(fcnt) - $past(ncnt));
    p_retire_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !fire && in_run) |=> fcnt == $past(fcnt) + 1);
endmodule

bind rn_rename_unit rn_rename_chk #(.GROUP(GROUP), .PHYS(PHYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_valid_i  (grp_valid_i),
    .grp_ready_o  (grp_ready_o),
    .flush_i      (flush_i),
    .ret_valid_i  (ret_valid_i),
    .in_run       (in_run),
    .need         (need),
    .free_vec     (free_vec),
    .slot_dst_p_o (slot_dst_p_o)
);

// File: tb/rn_rename_unit_test.sv
module rn_rename_unit_test;
    localparam int G  = 6;
    localparam int A  = 38;
    localparam int P  = 180;
    localparam int AW = $clog2(A);
    localparam int PW = $clog2(P);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid_i = 1'b0;
    logic [0:0] grp_thread_i = '0;
    logic [G-1:0] slot_valid_i = '0, slot_wr_i = '0;
    logic [G-1:0][AW-1:0] slot_dst_i = '0, slot_srca_i = '0, slot_srcb_i = '0;
    logic grp_ready_o;
    logic [G-1:0][PW-1:0] slot_srca_p_o, slot_srcb_p_o, slot_dst_p_o;
    logic ret_valid_i = 1'b0;
    logic [0:0] ret_thread_i = '0;
    logic [AW-1:0] ret_arch_i = '0;
    logic [PW-1:0] ret_phys_i = '0;
    logic flush_i = 1'b0;
    logic [0:0] flush_thread_i = '0;

    always #5 clk = ~clk;

    rn_rename_unit uut (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int m_spec [2][A];
    int m_cmt  [2][A];
    bit m_used [P];
    bit m_cm   [P];
    int m_own  [P];
    int q_arch [2][$];
    int q_phys [2][$];
    bit pend_v = 0;
    int pend_t = 0;
    string rdy_tag = "R5", src_tag = "R2", dst_tag = "R4";

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int free_cnt();
        int c = 0;
        for (int p = 0; p < P; p++) if (!m_used[p]) c++;
        return c;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++)
            for (int a = 0; a < A; a++) begin m_spec[t][a] = t*A + a; m_cmt[t][a] = t*A + a; end
        for (int p = 0; p < P; p++) begin m_used[p] = (p < 2*A); m_cm[p] = (p < 2*A); m_own[p] = p / A; end
    endtask

    // compare at the sampling point, then advance the model by one clock
    task automatic check_and_update();
        int nd = 0, t, alloc[G], sa, sb;
        bit exp_rdy, ba, bb;
        bit mark[P];
        t = grp_thread_i;
        for (int g = 0; g < G; g++) if (grp_valid_i && slot_valid_i[g] && slot_wr_i[g]) nd++;
        exp_rdy = !flush_i && !pend_v && (free_cnt() >= nd);
        chk((flush_i || pend_v) ? "R7" : rdy_tag, grp_ready_o, exp_rdy);
        if (grp_valid_i && exp_rdy) begin
            for (int p = 0; p < P; p++) mark[p] = m_used[p];
            for (int g = 0; g < G; g++) begin
                alloc[g] = 0;
                if (slot_valid_i[g] && slot_wr_i[g])
                    for (int p = 0; p < P; p++) if (!mark[p]) begin alloc[g] = p; mark[p] = 1; break; end
            end
            for (int g = 0; g < G; g++) begin
                if (!slot_valid_i[g]) continue;
                sa = m_spec[t][slot_srca_i[g]]; sb = m_spec[t][slot_srcb_i[g]]; ba = 0; bb = 0;
                for (int j = 0; j < g; j++) if (slot_valid_i[j] && slot_wr_i[j]) begin
                    if (slot_dst_i[j] == slot_srca_i[g]) begin sa = alloc[j]; ba = 1; end
                    if (slot_dst_i[j] == slot_srcb_i[g]) begin sb = alloc[j]; bb = 1; end
                end
                chk(ba ? "R3" : src_tag, slot_srca_p_o[g], sa);
                chk(bb ? "R3" : src_tag, slot_srcb_p_o[g], sb);
                chk(nd == G ? "R10" : dst_tag, slot_dst_p_o[g], slot_wr_i[g] ? alloc[g] : 0);
            end
            for (int g = 0; g < G; g++) if (slot_valid_i[g] && slot_wr_i[g]) begin
                m_spec[t][slot_dst_i[g]] = alloc[g];
                m_used[alloc[g]] = 1; m_cm[alloc[g]] = 0; m_own[alloc[g]] = t;
                q_arch[t].push_back(int'(slot_dst_i[g])); q_phys[t].push_back(alloc[g]);
            end
        end
        if (pend_v)
            for (int p = 0; p < P; p++) if (m_used[p] && !m_cm[p] && m_own[p] == pend_t) m_used[p] = 0;
        if (ret_valid_i) begin
            int old = m_cmt[ret_thread_i][ret_arch_i];
            m_used[old] = 0; m_cm[old] = 0;
            m_cmt[ret_thread_i][ret_arch_i] = ret_phys_i;
            m_used[ret_phys_i] = 1; m_cm[ret_phys_i] = 1;
        end
        if (pend_v) for (int a = 0; a < A; a++) m_spec[pend_t][a] = m_cmt[pend_t][a];
        pend_v = flush_i; pend_t = flush_thread_i;
    endtask

    task automatic step();
        #3;
        check_and_update();
        @(posedge clk); #1;
        grp_valid_i = 0; ret_valid_i = 0; flush_i = 0; slot_valid_i = '0; slot_wr_i = '0;
    endtask

    task automatic put(int g, bit w, int d, int a, int b);
        slot_valid_i[g] = 1; slot_wr_i[g] = w;
        slot_dst_i[g] = AW'(d); slot_srca_i[g] = AW'(a); slot_srcb_i[g] = AW'(b);
    endtask

    task automatic do_retire(int t);
        ret_valid_i = 1; ret_thread_i = 1'(t);
        ret_arch_i = AW'(q_arch[t].pop_front()); ret_phys_i = PW'(q_phys[t].pop_front());
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(posedge clk); #1;

        // R1: reset mappings and first allocations
        src_tag = "R1"; dst_tag = "R1";
        grp_valid_i = 1; grp_thread_i = 1;
        put(0, 1, 5, 5, 37); put(1, 0, 0, 5, 0); put(2, 1, 9, 9, 5); put(3, 1, 5, 5, 2);
        step();
        grp_valid_i = 1; grp_thread_i = 0;
        put(0, 1, 3, 3, 37); put(1, 0, 0, 0, 1);
        step();
        src_tag = "R2"; dst_tag = "R4";

        // R7 R8 R9: flush thread 0 while thread 1 holds speculative registers
        flush_i = 1; flush_thread_i = 0;
        grp_valid_i = 1; grp_thread_i = 1; put(0, 1, 1, 1, 1);
        q_arch[0].delete(); q_phys[0].delete();
        step();
        grp_valid_i = 1; grp_thread_i = 0; put(0, 1, 4, 4, 4);
        step();
        src_tag = "R7"; dst_tag = "R8";
        grp_valid_i = 1; grp_thread_i = 0; put(0, 1, 3, 3, 4);
        step();
        src_tag = "R9";
        grp_valid_i = 1; grp_thread_i = 1; put(0, 0, 0, 5, 9); put(1, 0, 0, 1, 30);
        step();
        src_tag = "R2"; dst_tag = "R4";

        // R5 R10: drain the pool with full writing groups, no retirement
        rdy_tag = "R5";
        for (int i = 0; i < 24; i++) begin
            grp_valid_i = 1; grp_thread_i = 1'(i % 2);
            for (int g = 0; g < G; g++) put(g, 1, (i + g) % A, (i * 3 + g) % A, g);
            step();
        end

        // R6: a retirement makes one register allocatable in the next cycle
        rdy_tag = "R6";
        do_retire(1);
        step();
        grp_valid_i = 1; grp_thread_i = 0; put(0, 1, 7, 7, 8);
        step();
        rdy_tag = "R5";

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            grp_valid_i = ($urandom % 10) < 8;
            grp_thread_i = 1'($urandom % 2);
            for (int g = 0; g < G; g++)
                if ($urandom % 2) put(g, 1'($urandom % 2), $urandom % A, $urandom % A, $urandom % A);
            if (($urandom % 10) < 7) begin
                int rt = $urandom % 2;
                if (q_arch[rt].size() == 0) rt = 1 - rt;
                if (q_arch[rt].size() != 0 && !(pend_v && pend_t == rt)) do_retire(rt);
            end
            if (($urandom % 50) == 0 && !pend_v) begin
                flush_i = 1; flush_thread_i = 1'($urandom % 2);
                q_arch[flush_thread_i].delete(); q_phys[flush_thread_i].delete();
            end
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule